// File: doc/BRIEF.md
# FIFO-fed PWM generator

A single-channel pulse-width modulator that is programmed through a small word-addressed register port. Software queues duty values into a short sample queue. The generator takes one value from the queue at each period boundary and holds it for 1, 2, 4 or 8 periods before it takes the next. When the queue runs dry at a boundary, the value already in use is kept.

The period counter advances on a prescaled tick. A 12-bit control field sets the division ratio. One output period lasts the programmed period value plus two ticks. The output is high from the start of a period until the counter reaches the active duty value. An output-mode field can invert the waveform or disconnect it. While the generator is disabled, the pin is held low whatever mode is selected.

A self-clearing software reset returns every register and the queue to their idle state. Sticky status flags report the queue emptying, a period wrap, a compare hit and a write to a full queue. Software clears each flag by writing 1 to it.

Top module: `fifo_pwm`

## Requirements
- R1: Word address 0 is control, 1 is status, 3 is the duty-sample queue and 4 is the period register. The period register reads back the value written to it. Every other address reads 0.
- R2: One output period lasts P+2 ticks, where P is the period register value. An all-ones P behaves exactly like all-ones minus 1.
- R3: Control bits 15:4 hold the tick divide ratio minus 1. A field value of N produces one tick every N+1 clocks, up to 4096 clocks for 0xFFF.
- R4: Control bits 19:18 choose the output mode. In mode 0 the output is high while the period counter is below the active sample. Mode 1 is the inverse of mode 0 while enabled. Modes 2 and 3 hold the output at 0.
- R5: Control bit 0 enables the generator. On the clock after enabling, the oldest queued sample becomes active if the queue is not empty. While bit 0 is 0, the output is 0 in every mode.
- R6: Control bits 2:1 (values 0 to 3) make each sample last 1, 2, 4 or 8 periods. A boundary that finds the queue empty keeps the current sample.
- R7: A write to address 3 queues a sample in a queue of depth 4. Status bits 2:0 give the number of queued samples. A write to a full queue is dropped and sets status bit 6.
- R8: Status bit 3 is set when a take empties the queue. Bit 4 is set on each period wrap. Bit 5 is set on a tick where the counter equals the active sample. Writing 1 to any of bits 6:3 clears that bit, and a set in the same cycle wins over the clear.
- R9: Writing control with bit 3 set clears control, period, queue, flags and active sample. Bit 3 then reads 1 for SWR_CYCLES clocks, and bus writes during that window are ignored.
- R10: Address 3 reads the active sample while enabled and 0 while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with an 8-bit sample and period width, a queue of depth 4 and a 3-cycle software reset. With 8-bit values the all-ones period clamp (255 treated as 254) fits in a run of a few hundred clocks, next to a direct comparison against 254. With the narrow width, a sweep over small periods, three prescaler ratios, all four repeat counts and both live polarities stays short. In that sweep the bench compares the output against an arithmetic model on every clock. That model includes the samples equal to zero or to the full period, and the reuse of the last sample once the queue drains.

// File: rtl/fifo_pwm_pkg.sv
package fifo_pwm_pkg;
  // Word addresses of the register port
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_STAT = 3'd1;
  localparam logic [2:0] ADR_SMPL = 3'd3;
  localparam logic [2:0] ADR_PERD = 3'd4;

  // Control field positions
  localparam int PRESC_W  = 12;
  localparam int EN_BIT   = 0;
  localparam int RPT_LSB  = 1;
  localparam int SWR_BIT  = 3;
  localparam int PRESC_LSB = 4;
  localparam int MODE_LSB = 18;

  // Status flag field starts here (fe, rov, cmp, fwe upward)
  localparam int FLAG_LSB = 3;

  typedef enum logic [1:0] {
    OUT_NORMAL  = 2'd0,
    OUT_INVERT  = 2'd1,
    OUT_OFF     = 2'd2,
    OUT_OFF_ALT = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic fwe;  // write to full queue
    logic cmp;  // compare hit
    logic rov;  // period wrap
    logic fe;   // queue emptied by a take
  } stat_flags_t;
endpackage

// File: rtl/fifo_pwm_prescaler.sv
module fifo_pwm_prescaler #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] ratio_m1,
  output logic         tick
);
  logic [W-1:0] div_q, div_d;

  // >= keeps a lowered ratio from running the counter round its full range
  assign tick = run && (div_q >= ratio_m1);

  always_comb begin
    div_d = div_q;
    if (!run)      div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/fifo_pwm_sample_fifo.sv
module fifo_pwm_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             push,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             pop,
  output logic [DATA_W-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = slot_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = ptr_inc(wp_q);
      if (pop_ok)  rp_d = ptr_inc(rp_q);
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; a slot is only read after it was written
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && !flush && (wp_q == PTR_W'(i))) slot_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/fifo_pwm_engine.sv
module fifo_pwm_engine #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              enable,
  input  logic              tick,
  input  logic [DATA_W-1:0] period_val,
  input  logic [1:0]        rpt_sel,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              run,
  output logic              pop,
  output logic              wrap,
  output logic              cmp_hit,
  output logic              below,
  output logic [DATA_W-1:0] active
);
  localparam logic [DATA_W-1:0] ALL1 = '1;

  logic              first_q, first_d;
  logic [DATA_W-1:0] cnt_q, cnt_d, act_q, act_d;
  logic [2:0]        rep_q, rep_d, reps_m1;
  logic [DATA_W-1:0] period_eff, last;
  logic              load, rep_done;

  assign period_eff = (period_val == ALL1) ? ALL1 - 1'b1 : period_val;
  assign last       = period_eff + 1'b1;

  always_comb begin
    case (rpt_sel)
      2'd0:    reps_m1 = 3'd0;
      2'd1:    reps_m1 = 3'd1;
      2'd2:    reps_m1 = 3'd3;
      default: reps_m1 = 3'd7;
    endcase
  end

  assign load     = enable && first_q;
  assign run      = enable && !first_q;
  assign wrap     = run && tick && (cnt_q >= last);
  assign rep_done = (rep_q >= reps_m1);
  assign pop      = !fifo_empty && (load || (wrap && rep_done));
  assign cmp_hit  = run && tick && (cnt_q == act_q);
  assign below    = (cnt_q < act_q);
  assign active   = act_q;

  always_comb begin
    first_d = flush || !enable;
    cnt_d   = cnt_q;
    rep_d   = rep_q;
    act_d   = act_q;
    if (flush || !enable || load) begin
      cnt_d = '0;
      rep_d = '0;
    end else if (run && tick) begin
      if (wrap) begin
        cnt_d = '0;
        rep_d = rep_done ? 3'd0 : rep_q + 3'd1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (flush)    act_d = '0;
    else if (pop) act_d = fifo_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
      rep_q   <= '0;
      act_q   <= '0;
    end else begin
      first_q <= first_d;
      cnt_q   <= cnt_d;
      rep_q   <= rep_d;
      act_q   <= act_d;
    end
  end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
  import fifo_pwm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int SWR_W = $clog2(SWR_CYCLES + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // Register state
  logic               ctl_en_q, ctl_en_d;
  logic [1:0]         ctl_rpt_q, ctl_rpt_d;
  logic [PRESC_W-1:0] ctl_presc_q, ctl_presc_d;
  out_mode_e          ctl_mode_q, ctl_mode_d;
  logic [DATA_W-1:0]  per_q, per_d;
  stat_flags_t        flags_q, flags_d, flag_set, flag_clr;
  logic [SWR_W-1:0]   swr_cnt_q, swr_cnt_d;

  logic swr_busy, wr_ok, ctrl_wr, stat_wr, sample_wr, per_wr, swr_start;

  // Datapath links
  logic [DATA_W-1:0] fifo_data, active;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic              tick, run, wrap, cmp_hit, below;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:20], bus_wdata[17:16]};

  assign swr_busy  = (swr_cnt_q != '0);
  assign wr_ok     = bus_wr && !swr_busy;
  assign ctrl_wr   = wr_ok && (bus_addr == ADR_CTRL);
  assign stat_wr   = wr_ok && (bus_addr == ADR_STAT);
  assign sample_wr = wr_ok && (bus_addr == ADR_SMPL);
  assign per_wr    = wr_ok && (bus_addr == ADR_PERD);
  assign swr_start = ctrl_wr && bus_wdata[SWR_BIT];

  always_comb begin
    ctl_en_d    = ctl_en_q;
    ctl_rpt_d   = ctl_rpt_q;
    ctl_presc_d = ctl_presc_q;
    ctl_mode_d  = ctl_mode_q;
    per_d       = per_q;
    swr_cnt_d   = swr_cnt_q;
    if (swr_start) begin
      ctl_en_d    = 1'b0;
      ctl_rpt_d   = '0;
      ctl_presc_d = '0;
      ctl_mode_d  = OUT_NORMAL;
      per_d       = '0;
      swr_cnt_d   = SWR_W'(SWR_CYCLES);
    end else begin
      if (ctrl_wr) begin
        ctl_en_d    = bus_wdata[EN_BIT];
        ctl_rpt_d   = bus_wdata[RPT_LSB +: 2];
        ctl_presc_d = bus_wdata[PRESC_LSB +: PRESC_W];
        ctl_mode_d  = out_mode_e'(bus_wdata[MODE_LSB +: 2]);
      end
      if (per_wr)   per_d     = bus_wdata[DATA_W-1:0];
      if (swr_busy) swr_cnt_d = swr_cnt_q - 1'b1;
    end
  end

  // Flags: set wins over a clear in the same cycle, reset wins over both
  always_comb begin
    flag_set.fwe = sample_wr && fifo_full;
    flag_set.cmp = cmp_hit;
    flag_set.rov = wrap;
    flag_set.fe  = fifo_pop && (fifo_count == CNT_W'(1));
    flag_clr     = stat_wr ? stat_flags_t'(bus_wdata[FLAG_LSB +: 4]) : '0;
    if (swr_start) flags_d = '0;
    else           flags_d = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_en_q    <= 1'b0;
      ctl_rpt_q   <= '0;
      ctl_presc_q <= '0;
      ctl_mode_q  <= OUT_NORMAL;
      per_q       <= '0;
      flags_q     <= '0;
      swr_cnt_q   <= '0;
    end else begin
      ctl_en_q    <= ctl_en_d;
      ctl_rpt_q   <= ctl_rpt_d;
      ctl_presc_q <= ctl_presc_d;
      ctl_mode_q  <= ctl_mode_d;
      per_q       <= per_d;
      flags_q     <= flags_d;
      swr_cnt_q   <= swr_cnt_d;
    end
  end

  fifo_pwm_sample_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i),
    .flush (swr_start),
    .push  (sample_wr),
    .wdata (bus_wdata[DATA_W-1:0]),
    .pop   (fifo_pop),
    .rdata (fifo_data),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  fifo_pwm_prescaler #(.W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .ratio_m1 (ctl_presc_q),
    .tick     (tick)
  );

  fifo_pwm_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_i),
    .flush      (swr_start),
    .enable     (ctl_en_q),
    .tick       (tick),
    .period_val (per_q),
    .rpt_sel    (ctl_rpt_q),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .run        (run),
    .pop        (fifo_pop),
    .wrap       (wrap),
    .cmp_hit    (cmp_hit),
    .below      (below),
    .active     (active)
  );

  // Output stage: low whenever not running, whatever the mode
  always_comb begin
    case (ctl_mode_q)
      OUT_NORMAL: pwm_out = run && below;
      OUT_INVERT: pwm_out = run && !below;
      default:    pwm_out = 1'b0;
    endcase
  end

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = {12'b0, ctl_mode_q, 2'b0, ctl_presc_q, swr_busy, ctl_rpt_q, ctl_en_q};
      ADR_STAT: bus_rdata = {25'b0, flags_q, 3'(fifo_count)};
      ADR_SMPL: bus_rdata = ctl_en_q ? 32'(active) : 32'd0;
      ADR_PERD: bus_rdata = 32'(per_q);
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/fifo_pwm_checker.sv
module fifo_pwm_checker #(
  parameter int CNT_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             ctl_en,
  input logic [1:0]       ctl_mode,
  input logic [CNT_W-1:0] fifo_count,
  input logic             sample_wr,
  input logic             fifo_full,
  input logic             fwe_flag,
  input logic             rov_flag,
  input logic             wrap,
  input logic             flush,
  input logic             swr_busy
);
  // R5: disabled output is low in every mode
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !pwm_out);

  // R4: disconnected modes hold the output low
  a_r4_off_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mode[1] |-> !pwm_out);

  // R7: occupancy never passes the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  // R7: a write into a full queue raises the error flag
  a_r7_full_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_wr && fifo_full) |=> fwe_flag);

  // R8: a period wrap raises the roll-over flag
  a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !flush) |=> rov_flag);

  // R9: generator stays disabled during software reset
  a_r9_busy_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> !ctl_en);

  // R9: the queue is empty when the reset window opens
  a_r9_busy_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swr_busy) |-> (fifo_count == '0));
endmodule

bind fifo_pwm fifo_pwm_checker #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_out    (pwm_out),
  .ctl_en     (ctl_en_q),
  .ctl_mode   (ctl_mode_q),
  .fifo_count (fifo_count),
  .sample_wr  (sample_wr),
  .fifo_full  (fifo_full),
  .fwe_flag   (flags_q.fwe),
  .rov_flag   (flags_q.rov),
  .wrap       (wrap),
  .flush      (swr_start),
  .swr_busy   (swr_busy)
);

// File: tb/sim_fifo_pwm.sv
module sim_fifo_pwm;
  localparam int DW   = 8;
  localparam int DEP  = 4;
  localparam int SWR  = 3;
  localparam int ALL1 = (1 << DW) - 1;

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;
  int smp[4];
  logic [31:0] rv;

  fifo_pwm #(.DATA_W(DW), .FIFO_DEPTH(DEP), .SWR_CYCLES(SWR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // 125 MHz: 8 time units per period
  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic soft_reset();
    bus_write(3'd0, 32'h8);
    repeat (SWR + 1) @(negedge clk);
  endtask

  function automatic logic exp_out(int k, int p, int presc, int mode, int rpt, int n);
    int peff = (p == ALL1) ? ALL1 - 1 : p;
    int len  = peff + 2;
    int t    = k / (presc + 1);
    int j    = t / len;
    int c    = t % len;
    int idx  = j / (1 << rpt);
    logic bl;
    if (idx > n - 1) idx = n - 1;
    bl = (c < smp[idx]);
    if (mode == 0) return bl;
    if (mode == 1) return !bl;
    return 1'b0;
  endfunction

  // Program, enable and compare the output on every clock against the model
  task automatic run_case(input string req, input int p, input int presc,
                          input int mode, input int rpt, input int n);
    int peff = (p == ALL1) ? ALL1 - 1 : p;
    int total = (n * (1 << rpt) + 1) * (peff + 2) * (presc + 1);
    int bad = 0;
    int bad_k = 0;
    logic bad_act = 1'b0;
    logic bad_exp = 1'b0;
    soft_reset();
    bus_write(3'd4, 32'(p));
    for (int i = 0; i < n; i++) bus_write(3'd3, 32'(smp[i]));
    bus_write(3'd0, 32'd1 | 32'(rpt << 1) | 32'(presc << 4) | 32'(mode << 18));
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (pwm_out !== exp_out(k, p, presc, mode, rpt, n)) begin
        if (bad == 0) begin
          bad_k   = k;
          bad_act = pwm_out;
          bad_exp = exp_out(k, p, presc, mode, rpt, n);
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s p=%0d presc=%0d mode=%0d rpt=%0d clk=%0d actual=%0b expected=%0b",
               req, p, presc, mode, rpt, bad_k, bad_act, bad_exp);
    end
  endtask

  // Watchdog: an expired run is a failed check and still reports
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int plist[3];
    plist = '{0, 1, 3};
    rst_n = 1'b0;
    bus_wr = 1'b0;
    bus_addr = 3'd0;
    bus_wdata = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    bus_read(3'd0, rv); check("R9 reset ctrl", rv, 32'h0);
    bus_read(3'd1, rv); check("R7 reset status", rv, 32'h0);
    bus_read(3'd4, rv); check("R1 reset period", rv, 32'h0);
    check("R5 reset output", 32'(pwm_out), 32'h0);

    // R1: map and readback
    bus_write(3'd4, 32'hA5);
    bus_read(3'd4, rv); check("R1 period readback", rv, 32'hA5);
    bus_read(3'd2, rv); check("R1 hole addr2", rv, 32'h0);
    bus_read(3'd6, rv); check("R1 hole addr6", rv, 32'h0);

    // R7: queue occupancy and overflow
    soft_reset();
    for (int i = 1; i <= DEP; i++) begin
      bus_write(3'd3, 32'(i));
      bus_read(3'd1, rv);
      check("R7 count", rv, 32'(i));
    end
    bus_write(3'd3, 32'h55);
    bus_read(3'd1, rv); check("R7 overflow flag", rv, 32'h44);
    bus_write(3'd1, 32'h40);
    bus_read(3'd1, rv); check("R8 clear overflow", rv, 32'h04);

    // R9: software reset window, writes ignored inside it
    bus_write(3'd4, 32'h9);
    bus_write(3'd0, 32'h8);
    bus_read(3'd0, rv); check("R9 busy reads one", rv, 32'h8);
    bus_write(3'd4, 32'h7);
    repeat (SWR + 1) @(negedge clk);
    bus_read(3'd0, rv); check("R9 busy self-clears", rv, 32'h0);
    bus_read(3'd4, rv); check("R9 period cleared, write ignored", rv, 32'h0);
    bus_read(3'd1, rv); check("R9 queue flushed", rv, 32'h0);

    // R2 R3 R4 R5 R6: waveform sweep
    foreach (plist[pi]) begin
      for (int presc = 0; presc < 3; presc++) begin
        for (int rpt = 0; rpt < 4; rpt++) begin
          for (int mode = 0; mode < 2; mode++) begin
            int len = plist[pi] + 2;
            smp[0] = (presc + rpt) % (len + 1);
            smp[1] = len;
            smp[2] = (plist[pi] + 1 + mode) % (len + 1);
            run_case("R2 R3 R4 R5 R6 sweep", plist[pi], presc, mode, rpt, 3);
          end
        end
      end
    end

    // R5: disabled output low while inverted
    bus_write(3'd0, 32'(1 << 18));
    check("R5 inverted but disabled", 32'(pwm_out), 32'h0);
    repeat (5) @(negedge clk);
    check("R5 stays low", 32'(pwm_out), 32'h0);

    // R2: all-ones period clamps to all-ones minus one
    smp[0] = 8'h80; smp[1] = 8'hFF;
    run_case("R2 all-ones period", ALL1, 0, 0, 0, 2);
    run_case("R2 all-ones minus one", ALL1 - 1, 0, 0, 0, 2);

    // R3: largest divide ratio
    smp[0] = 1;
    run_case("R3 divide by 4096", 0, 12'hFFF, 0, 0, 1);

    // R4: disconnected mode
    smp[0] = 2; smp[1] = 1;
    run_case("R4 mode 2 off", 2, 1, 2, 0, 2);

    // R8 R10: flags and sample readback
    smp[0] = 1; smp[1] = 2;
    run_case("R4 R6 flag run", 1, 0, 0, 0, 2);
    bus_read(3'd1, rv); check("R8 flags after run", rv, 32'h38);
    bus_read(3'd3, rv); check("R10 active sample", rv, 32'h2);
    bus_write(3'd0, 32'h0);
    bus_read(3'd3, rv); check("R10 disabled sample read", rv, 32'h0);
    bus_write(3'd1, 32'h08);
    bus_read(3'd1, rv); check("R8 partial clear", rv, 32'h30);
    bus_write(3'd1, 32'h30);
    bus_read(3'd1, rv); check("R8 full clear", rv, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule